// File: doc/BRIEF.md
# Prioritised Interrupt Router

This block collects up to 32 peripheral interrupt lines and turns them into two active-low processor requests: a normal request and a fast request. Each line is edge-detected. A rising edge is recorded in a raw pending register. A per-line routing bit chooses the path for that line, and a per-line block bit keeps the line away from both outputs while its event is still recorded.

Lines on the normal path are arbitrated, and a lower index wins. The winner is copied into a one-hot service register. That register holds the winner until software acknowledges it, so the normal request output stays low for exactly one serviced source at a time. Lines on the fast path skip the service register. The fast request output is low whenever any raw-pending, unblocked, fast-routed line exists.

Software uses a plain synchronous register port. It reads through a combinational read mux. Its writes load the routing and block registers directly and clear pending bits by writing ones. Once a source has been serviced, software acknowledges both the raw bit and the service bit.

Top module: `irq_router`

## Requirements
- R1: After reset, the raw pending register (offset 0x00) and the service register (offset 0x10) read 0, the routing register (offset 0x04) reads 0, the block register (offset 0x08) reads all ones, and both request outputs are high.
- R2: A 0-to-1 transition on input line i sets raw pending bit i at the next clock edge. A line held high does not set the bit again after it has been cleared.
- R3: Writing to offset 0x00 or 0x10 clears every bit written as 1 and leaves bits written as 0 unchanged. When a rising edge and a clear hit the same raw bit in the same cycle, the bit ends up set.
- R4: Writes to offset 0x04 and 0x08 load those registers whole, and the registers read back the stored value. Other offsets read 0, and writes to them change nothing.
- R5: While the service register is empty, the next clock edge loads it with a one-hot copy of the lowest-index bit that is raw-pending, unblocked (block bit 0) and normal-routed (routing bit 0). The service register never has more than one bit set.
- R6: A set service bit stays unchanged, even when a higher-priority source arrives, until software clears it. The normal request output is low exactly while the service register is non-zero.
- R7: The fast request output is low while any raw-pending bit has routing bit 1 and block bit 0. Such sources never enter the service register. Both outputs may be low in the same cycle.
- R8: A blocked source still sets its raw pending bit but affects neither output. When it is unblocked, it is arbitrated one cycle after the block register changes.
- R9: Clearing only the service bit while the raw bit remains set causes the same source to be loaded again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 32 | Peripheral interrupt lines, rising-edge sensitive |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_n | output | 1 | Normal request, active low |
| fiq_n | output | 1 | Fast request, active low |

## Verification
Two functions can meet on the same raw bit in one cycle: a new rising edge on a line, and a software write-one clear of that same bit. The bench provokes this by raising line 9 on the same clock edge that a clear of bit 9 is written to offset 0x00. It then judges the result by reading the raw register afterwards and expecting the bit to be set. A second overlap is a normal-path winner and a fast-path source pending together. For this case the bench expects both outputs low, and it expects the service register to hold the normal source even though the fast one has a lower index.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NSRC = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  output logic            irq_n,
  output logic            fiq_n
);
  localparam logic [AW-1:0] OFS_RAW  = AW'(5'h00);
  localparam logic [AW-1:0] OFS_MODE = AW'(5'h04);
  localparam logic [AW-1:0] OFS_BLK  = AW'(5'h08);
  localparam logic [AW-1:0] OFS_SVC  = AW'(5'h10);

  logic [NSRC-1:0] req_q, raw, route, blk, svc;
  logic [NSRC-1:0] rise, clr_raw, clr_svc, cand, win, fast;

  assign rise    = req_i & ~req_q;
  assign clr_raw = (wr_en && addr == OFS_RAW) ? wdata : '0;
  assign clr_svc = (wr_en && addr == OFS_SVC) ? wdata : '0;
  assign cand    = raw & ~blk & ~route;
  assign win     = cand & (~cand + NSRC'(1));
  assign fast    = raw & ~blk & route;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      raw   <= '0;
      route <= '0;
      blk   <= '1;
      svc   <= '0;
    end else begin
      req_q <= req_i;
      raw   <= (raw & ~clr_raw) | rise;
      if (wr_en && addr == OFS_MODE) route <= wdata;
      if (wr_en && addr == OFS_BLK)  blk   <= wdata;
      if (|svc) svc <= svc & ~clr_svc;
      else      svc <= win;
    end
  end

  always_comb begin
    case (addr)
      OFS_RAW:  rdata = raw;
      OFS_MODE: rdata = route;
      OFS_BLK:  rdata = blk;
      OFS_SVC:  rdata = svc;
      default:  rdata = '0;
    endcase
  end

  assign irq_n = ~|svc;
  assign fiq_n = ~|fast;

  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((raw & $past(rise)) == $past(rise)));

  p_svc_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc));

  p_svc_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|svc) |-> (($past(cand) & svc) == svc));

  p_svc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|svc) && !(|(clr_svc & svc))) |=> (svc == $past(svc)));

  p_blk_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_BLK) |=> (blk == $past(wdata)));

  p_route_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MODE) |=> (route == $past(wdata)));
endmodule

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] req_i = '0;
  logic        wr_en = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n, fiq_n;

  irq_router dut (.clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en(wr_en), .addr(addr),
                  .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .fiq_n(fiq_n));

  always #2 clk = ~clk;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  initial forever begin
    item_t it;
    logic [31:0] act;
    wait (q.size() != 0);
    #0.1;
    it = q.pop_front();
    act = (it.kind == 0) ? rdata : (it.kind == 1) ? {31'b0, irq_n} : {31'b0, fiq_n};
    compared++;
    if (act !== it.exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
    end
  end

  task automatic push(input int k, input logic [4:0] a, input logic [31:0] v, input string t);
    item_t it;
    addr = a;
    it.kind = k; it.exp = v; it.tag = t;
    q.push_back(it);
    #0.2;
  endtask
  task automatic exp_reg(input logic [4:0] a, input logic [31:0] v, input string t);
    push(0, a, v, t);
  endtask
  task automatic exp_out(input logic irq, input logic fiq, input string t);
    push(1, 5'h00, {31'b0, irq}, {t, " irq_n"});
    push(2, 5'h00, {31'b0, fiq}, {t, " fiq_n"});
  endtask
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic pulse(input int i);
    @(negedge clk); req_i[i] = 1'b1;
    @(negedge clk); req_i[i] = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    step(3); rst_n = 1; step(1);
    // R1 reset state
    exp_reg(5'h00, 32'h0, "R1 raw");
    exp_reg(5'h04, 32'h0, "R1 route");
    exp_reg(5'h08, 32'hFFFF_FFFF, "R1 block");
    exp_reg(5'h10, 32'h0, "R1 svc");
    exp_out(1, 1, "R1");

    wr(5'h08, 32'h0);
    pulse(14);
    exp_reg(5'h00, 32'h0000_4000, "R2 raw set by edge");
    exp_reg(5'h10, 32'h0, "R5 svc not yet loaded");
    step(1);
    exp_reg(5'h10, 32'h0000_4000, "R5 svc loaded");
    exp_out(0, 1, "R6 irq low");

    pulse(3); step(1);
    exp_reg(5'h00, 32'h0000_4008, "R2 second source");
    exp_reg(5'h10, 32'h0000_4000, "R6 winner held");

    wr(5'h10, 32'h0010_4000);
    exp_reg(5'h10, 32'h0, "R3 svc cleared");
    exp_out(1, 1, "R6 irq released");
    step(1);
    exp_reg(5'h10, 32'h0000_0008, "R5 lowest index wins");

    wr(5'h00, 32'h0000_4000);
    exp_reg(5'h00, 32'h0000_0008, "R3 zero bits kept");
    wr(5'h00, 32'h0000_0008);
    @(negedge clk); req_i[3] = 1'b1;
    step(1);
    exp_reg(5'h00, 32'h0000_0008, "R2 edge on line 3");
    wr(5'h00, 32'h0000_0008);
    step(2);
    exp_reg(5'h00, 32'h0, "R2 held level no re-set");
    req_i[3] = 1'b0;
    wr(5'h10, 32'h0000_0008); step(1);
    exp_reg(5'h10, 32'h0, "R5 empty with no candidate");
    exp_out(1, 1, "R6 idle");

    // R8 blocked source
    wr(5'h08, 32'h0000_0020);
    pulse(5); step(1);
    exp_reg(5'h00, 32'h0000_0020, "R8 blocked still recorded");
    exp_reg(5'h10, 32'h0, "R8 blocked not serviced");
    exp_out(1, 1, "R8 blocked");
    wr(5'h08, 32'h0);
    exp_reg(5'h10, 32'h0, "R8 one cycle after unblock");
    step(1);
    exp_reg(5'h10, 32'h0000_0020, "R8 unblocked serviced");
    exp_reg(5'h08, 32'h0, "R4 block readback");
    wr(5'h00, 32'h0000_0020); wr(5'h10, 32'h0000_0020);

    // R7 fast path
    wr(5'h04, 32'h0000_0084);
    exp_reg(5'h04, 32'h0000_0084, "R4 route readback");
    pulse(7);
    exp_reg(5'h00, 32'h0000_0080, "R7 raw fast");
    exp_out(1, 0, "R7 fast low");
    step(1);
    exp_reg(5'h10, 32'h0, "R7 fast bypasses svc");
    wr(5'h08, 32'h0000_0080);
    exp_out(1, 1, "R8 fast blocked");
    wr(5'h08, 32'h0);
    exp_out(1, 0, "R7 fast unblocked");

    pulse(20); step(1);
    exp_reg(5'h10, 32'h0010_0000, "R7 svc holds normal source");
    exp_out(0, 0, "R7 both low");
    pulse(2);
    exp_reg(5'h10, 32'h0010_0000, "R7 lower fast source not in svc");
    wr(5'h00, 32'h0000_0084);
    exp_out(0, 1, "R7 fast released");
    wr(5'h00, 32'h0010_0000); wr(5'h10, 32'h0010_0000);
    exp_out(1, 1, "R6 all cleared");

    // R3 set beats clear in the same cycle
    @(negedge clk); wr_en = 1; addr = 5'h00; wdata = 32'h0000_0200; req_i[9] = 1'b1;
    @(negedge clk); wr_en = 0; req_i[9] = 1'b0;
    exp_reg(5'h00, 32'h0000_0200, "R3 set wins collision");
    wr(5'h00, 32'h0000_0200);
    exp_reg(5'h00, 32'h0, "R3 raw cleared");
    wr(5'h10, 32'h0000_0200); step(1);
    exp_reg(5'h10, 32'h0, "R3 svc cleared after collision");

    // R9 relatch
    pulse(11); step(1);
    exp_reg(5'h10, 32'h0000_0800, "R9 loaded");
    wr(5'h10, 32'h0000_0800);
    exp_reg(5'h10, 32'h0, "R9 svc cleared");
    step(1);
    exp_reg(5'h10, 32'h0000_0800, "R9 relatched");
    wr(5'h00, 32'h0000_0800); wr(5'h10, 32'h0000_0800); step(1);
    exp_out(1, 1, "R9 both cleared");

    // R4 unmapped offset
    wr(5'h0C, 32'hFFFF_FFFF);
    exp_reg(5'h0C, 32'h0, "R4 unmapped reads 0");
    exp_reg(5'h08, 32'h0, "R4 block untouched");
    exp_reg(5'h04, 32'h0000_0084, "R4 route untouched");

    wait (q.size() == 0); #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule